// File: doc/BRIEF.md
# MMC Command and Response Engine

This block drives the single-bit command line of a MultiMediaCard. Software loads the five command bytes into a small transmit queue, one byte per write. A falling edge on the command-enable input then sends a 48-bit frame, one bit per clock. The engine adds the start and transmission bits and the CRC7 itself, and it finishes the frame with an end bit. While the frame is on the line, the output enable is high. At all other times the line is released to the card.

A falling edge on the response-enable input arms a response capture. The response length and the CRC check option are sampled at that edge. When the next command frame ends, the engine watches the line for the card's start bit. It then shifts in 48 or 136 bits and packs them into bytes in a receive buffer. Software reads that buffer through a pointer that auto-increments on each read. A one-cycle done pulse marks the end of each operation. A CRC error flag reports a mismatch between the CRC7 carried in the response and the CRC7 the engine computes.

Top module: `mmc_cmd_engine`

## Requirements
- R1: After reset, cmd_oe is 0, cmd_out is 1, done is 0 and crc_err is 0.
- R2: A command starts on the first clock edge that sees cmd_en low after having seen it high. In the next cycle cmd_oe is 1 and cmd_out carries frame bit 47. One further bit follows on each clock, down to bit 0.
- R3: Frame layout, sent MSB first: bit 47 = 0; bit 46 = 1; bits 45:40 = the low six bits of the first queued byte (its two upper bits are ignored); bits 39:8 = the next four queued bytes, first byte most significant; bits 7:1 = CRC7; bit 0 = 1.
- R4: The CRC7 uses polynomial x^7+x^3+1, starts from zero and covers frame bits 47:8. For example, index 0 with a zero argument gives 0x4A, so the last frame byte is 0x95.
- R5: The transmit queue holds 8 bytes. Each command consumes 5 bytes, in write order, starting where the previous command stopped and wrapping at 8. While txq_ptr_rst is 1, both queue pointers are held at zero.
- R6: A falling edge of rsp_en arms capture and samples rsp_short and crc_off. After the end bit of the next command, cmd_oe drops to 0. The engine ignores 1s on cmd_in until the first 0, which it takes as the response start bit.
- R7: The response length counts the start bit. It is 48 bits when rsp_short was 1 and 136 bits when it was 0. Received bits are packed MSB first: buffer byte i holds received bits 8i..8i+7, and the start bit lands in bit 7 of byte 0. This gives 6 or 17 bytes.
- R8: done is high for exactly one cycle. If capture is not armed, that cycle follows the command end bit. If capture is armed, it is the cycle after the clock edge that samples the last response bit.
- R9: When crc_off was 0, the engine computes CRC7 over response bits 0..39 (48-bit response) or bits 8..127 (136-bit response). It compares the result with bits 7:1 of the last response byte. On a mismatch, crc_err goes high together with done and stays high until the next capture is armed to start. When crc_off was 1, crc_err stays 0.
- R10: rxq_rd_data shows the buffer byte at the read pointer. Each cycle with rxq_rd_en high advances the pointer. While rxq_ptr_rst is 1, the pointer is held at zero.
- R11: A cmd_en falling edge that arrives while a command is being sent or a response is being captured is ignored. The frame in progress is unchanged and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Command start, acts on its falling edge |
| rsp_en | input | 1 | Response arm, acts on its falling edge |
| rsp_short | input | 1 | 1 selects a 48-bit response, 0 selects 136 bits |
| crc_off | input | 1 | 1 disables the response CRC7 check |
| txq_ptr_rst | input | 1 | Holds the transmit queue pointers at zero |
| rxq_ptr_rst | input | 1 | Holds the receive read pointer at zero |
| txq_wr_en | input | 1 | Writes txq_wr_data into the transmit queue |
| txq_wr_data | input | 8 | Command byte to queue |
| rxq_rd_en | input | 1 | Advances the receive read pointer |
| rxq_rd_data | output | 8 | Response byte at the read pointer |
| cmd_in | input | 1 | Command line as seen from the card side |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line output enable |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Response CRC7 mismatch flag |

## Verification
The assertions check the following on every cycle:
- the start and end bits of each frame;
- that the engine never drives the line while capturing;
- that done never lasts beyond one cycle;
- that the queue pointers stay at zero under their resets;
- that the capture stays in its wait state on idle-high input;
- that crc_err stays low when the check was disabled.

Only the bench scenarios can show the rest:
- the exact bit content of frames, including the two known CRC7 values;
- queue wrap-around across commands;
- the byte packing of both response lengths after a random idle gap;
- error detection on a corrupted response;
- that a command pulse arriving mid-transfer has no effect.

// File: rtl/mmc_cmd_pkg.sv
package mmc_cmd_pkg;
    localparam int CMD_BYTES  = 5;
    localparam int BODY_BITS  = CMD_BYTES * 8;
    localparam int FRAME_BITS = BODY_BITS + 8;

    typedef enum logic [1:0] {CAP_IDLE, CAP_WAIT, CAP_RX} cap_state_e;

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        logic fb;
        fb = b ^ c[6];
        return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction
endpackage

// File: rtl/mmc_txq.sv
module mmc_txq
    import mmc_cmd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ptr_rst,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pop,
    output logic [CMD_BYTES*DW-1:0]  body
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (ptr_rst) begin
            ptr_d = '0;
        end else begin
            if (wr_en) ptr_d.wr = ptr_q.wr + 1'b1;
            if (pop)   ptr_d.rd = ptr_q.rd + AW'(CMD_BYTES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !ptr_rst) mem_q[ptr_q.wr] <= wr_data;
    end

    for (genvar g = 0; g < CMD_BYTES; g++) begin : g_body
        assign body[(CMD_BYTES-g)*DW-1 -: DW] = mem_q[ptr_q.rd + AW'(g)];
    end

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (ptr_q.wr == '0 && ptr_q.rd == '0));
endmodule

// File: rtl/mmc_cmd_ser.sv
module mmc_cmd_ser
    import mmc_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [BODY_BITS-1:0] body,
    output logic                 cmd_out,
    output logic                 cmd_oe,
    output logic                 busy,
    output logic                 last
);
    typedef struct packed {
        logic                 active;
        logic [5:0]           cnt;
        logic [BODY_BITS-1:0] sh;
        logic [6:0]           crc;
    } ser_t;

    ser_t d, q;

    always_comb begin
        d = q;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.cnt    = '0;
                d.sh     = {2'b01, body[BODY_BITS-3:0]};
                d.crc    = '0;
            end
        end else begin
            if (q.cnt < 6'd40) begin
                d.crc = crc7_step(q.crc, q.sh[BODY_BITS-1]);
                d.sh  = {q.sh[BODY_BITS-2:0], 1'b0};
            end else if (q.cnt < 6'd47) begin
                d.crc = {q.crc[5:0], 1'b0};
            end
            if (q.cnt == 6'd47) d.active = 1'b0;
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_oe  = q.active;
    assign busy    = q.active;
    assign last    = q.active && (q.cnt == 6'd47);
    assign cmd_out = !q.active      ? 1'b1 :
                     (q.cnt < 6'd40) ? q.sh[BODY_BITS-1] :
                     (q.cnt < 6'd47) ? q.crc[6] : 1'b1;

    // R3
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    // R3
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> cmd_out);
endmodule

// File: rtl/mmc_rsp_cap.sv
module mmc_rsp_cap
    import mmc_cmd_pkg::*;
#(
    parameter int RX_BYTES = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       fmt_short,
    input  logic       chk_off,
    input  logic       cmd_in,
    input  logic       ptr_rst,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       last,
    output logic       crc_err
);
    localparam int RA = $clog2(RX_BYTES);

    typedef struct packed {
        cap_state_e    st;
        logic [7:0]    cnt;
        logic [7:0]    sh;
        logic [6:0]    crc;
        logic          short_l;
        logic          off_l;
        logic          err;
        logic [RA-1:0] rd;
    } cap_t;

    cap_t d, q;
    logic [7:0]    mem_q [RX_BYTES];
    logic          wr_en;
    logic [RA-1:0] wr_idx;
    logic [7:0]    nsh;
    logic          covered;
    logic [7:0]    len_m1;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        last    = 1'b0;
        nsh     = {q.sh[6:0], cmd_in};
        wr_idx  = RA'(q.cnt[7:3]);
        len_m1  = q.short_l ? 8'd47 : 8'd135;
        covered = q.short_l ? (q.cnt < 8'd40) : (q.cnt >= 8'd8 && q.cnt < 8'd128);

        if (ptr_rst)
            d.rd = '0;
        else if (rd_en)
            d.rd = (q.rd == RA'(RX_BYTES-1)) ? '0 : q.rd + 1'b1;

        unique case (q.st)
            CAP_IDLE: if (go) begin
                d.st      = CAP_WAIT;
                d.short_l = fmt_short;
                d.off_l   = chk_off;
                d.err     = 1'b0;
            end
            CAP_WAIT: if (!cmd_in) begin
                d.st  = CAP_RX;
                d.cnt = 8'd1;
                d.sh  = '0;
                d.crc = '0;
            end
            CAP_RX: begin
                d.sh = nsh;
                if (covered) d.crc = crc7_step(q.crc, cmd_in);
                if (q.cnt[2:0] == 3'd7) wr_en = 1'b1;
                if (q.cnt == len_m1) begin
                    d.st = CAP_IDLE;
                    last = 1'b1;
                    if (!q.off_l && (nsh[7:1] != q.crc)) d.err = 1'b1;
                end
                d.cnt = q.cnt + 1'b1;
            end
            default: d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: CAP_IDLE, default: '0};
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_idx] <= nsh;
    end

    assign rd_data = mem_q[q.rd];
    assign busy    = (q.st != CAP_IDLE);
    assign crc_err = q.err;

    // R9
    crc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last && q.off_l) |=> !crc_err);
    // R6
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == CAP_WAIT && cmd_in) |=> (q.st == CAP_WAIT));
    // R10
    rd_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst |=> (q.rd == '0));
endmodule

// File: rtl/mmc_cmd_engine.sv
module mmc_cmd_engine
    import mmc_cmd_pkg::*;
#(
    parameter int TXQ_DEPTH = 8,
    parameter int RX_BYTES  = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_en,
    input  logic       rsp_en,
    input  logic       rsp_short,
    input  logic       crc_off,
    input  logic       txq_ptr_rst,
    input  logic       rxq_ptr_rst,
    input  logic       txq_wr_en,
    input  logic [7:0] txq_wr_data,
    input  logic       rxq_rd_en,
    output logic [7:0] rxq_rd_data,
    input  logic       cmd_in,
    output logic       cmd_out,
    output logic       cmd_oe,
    output logic       done,
    output logic       crc_err
);
    typedef struct packed {
        logic cmd_en;
        logic rsp_en;
        logic armed;
        logic fmt;
        logic off;
        logic done;
    } ctl_t;

    ctl_t d, q;
    logic                 cmd_fall, rsp_fall, start, go;
    logic                 ser_busy, ser_last, cap_busy, cap_last;
    logic [BODY_BITS-1:0] body;

    assign cmd_fall = q.cmd_en && !cmd_en;
    assign rsp_fall = q.rsp_en && !rsp_en;
    assign start    = cmd_fall && !ser_busy && !cap_busy;
    assign go       = ser_last && q.armed;

    always_comb begin
        d        = q;
        d.cmd_en = cmd_en;
        d.rsp_en = rsp_en;
        if (go) d.armed = 1'b0;
        if (rsp_fall) begin
            d.armed = 1'b1;
            d.fmt   = rsp_short;
            d.off   = crc_off;
        end
        d.done = (ser_last && !q.armed) || cap_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    mmc_txq #(.DEPTH(TXQ_DEPTH), .DW(8)) u_txq (
        .clk(clk), .rst_n(rst_n), .ptr_rst(txq_ptr_rst),
        .wr_en(txq_wr_en), .wr_data(txq_wr_data), .pop(start), .body(body)
    );

    mmc_cmd_ser u_ser (
        .clk(clk), .rst_n(rst_n), .start(start), .body(body),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(ser_busy), .last(ser_last)
    );

    mmc_rsp_cap #(.RX_BYTES(RX_BYTES)) u_cap (
        .clk(clk), .rst_n(rst_n), .go(go), .fmt_short(q.fmt), .chk_off(q.off),
        .cmd_in(cmd_in), .ptr_rst(rxq_ptr_rst), .rd_en(rxq_rd_en),
        .rd_data(rxq_rd_data), .busy(cap_busy), .last(cap_last), .crc_err(crc_err)
    );

    assign done = q.done;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    line_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_oe && cap_busy));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fall && cap_busy) |=> !cmd_oe);
endmodule

// File: tb/mmc_cmd_engine_test.sv
module mmc_cmd_engine_test;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_en = 0, rsp_en = 0, rsp_short = 0, crc_off = 0;
    logic txq_ptr_rst = 0, rxq_ptr_rst = 0, txq_wr_en = 0, rxq_rd_en = 0;
    logic [7:0] txq_wr_data = '0;
    logic [7:0] rxq_rd_data;
    logic cmd_in = 1'b1;
    logic cmd_out, cmd_oe, done, crc_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mmc_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .rsp_en(rsp_en),
        .rsp_short(rsp_short), .crc_off(crc_off), .txq_ptr_rst(txq_ptr_rst),
        .rxq_ptr_rst(rxq_ptr_rst), .txq_wr_en(txq_wr_en), .txq_wr_data(txq_wr_data),
        .rxq_rd_en(rxq_rd_en), .rxq_rd_data(rxq_rd_data), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .done(done), .crc_err(crc_err)
    );

    function automatic logic [6:0] crc7_ref(input logic [119:0] m, input int n);
        logic [6:0] r = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb = m[i] ^ r[6];
            r = {r[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return r;
    endfunction

    function automatic logic [47:0] frame_of(input logic [5:0] idx, input logic [31:0] arg);
        logic [6:0] c = crc7_ref({80'b0, 2'b01, idx, arg}, 40);
        return {2'b01, idx, arg, c, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push_cmd(input logic [7:0] b0, input logic [31:0] arg);
        logic [39:0] v = {b0, arg};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            txq_wr_en = 1'b1;
            txq_wr_data = v[39-8*i -: 8];
        end
        @(negedge clk);
        txq_wr_en = 1'b0;
    endtask

    task automatic reset_txq();
        @(negedge clk); txq_ptr_rst = 1'b1;
        @(negedge clk); txq_ptr_rst = 1'b0;
    endtask

    task automatic arm(input logic short_fmt, input logic off);
        @(negedge clk); rsp_short = short_fmt; crc_off = off; rsp_en = 1'b1;
        @(negedge clk); rsp_en = 1'b0;
        @(negedge clk); rsp_short = ~short_fmt; crc_off = ~off;   // later values must not matter (R6)
    endtask

    // send a frame and compare it bit by bit; optionally pulse cmd_en mid-frame
    task automatic send_frame(input logic [47:0] exp, input string tag, input bit poke);
        logic [47:0] got = '0;
        bit oe_ok = 1;
        @(negedge clk); cmd_en = 1'b1;
        @(negedge clk); cmd_en = 1'b0;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            got[47-k] = cmd_out;
            if (!cmd_oe) oe_ok = 0;
            if (poke && k == 10) cmd_en = 1'b1;
            if (poke && k == 12) cmd_en = 1'b0;
        end
        chk(oe_ok && got == exp, tag, {88'b0, got}, {88'b0, exp});
    endtask

    task automatic expect_done_no_rsp(input string tag);
        @(negedge clk);
        chk(done && !cmd_oe, tag, {134'b0, done, cmd_oe}, 136'd2);
        @(negedge clk);
        chk(!done, "R8 done lasts one cycle", {135'b0, done}, 136'd0);
    endtask

    task automatic drive_rsp(input logic [135:0] rsp, input int len, input int gap,
                             input logic exp_err, input string tag);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (g == 0) chk(!cmd_oe && !done, "R6 line released, no early done", {134'b0, cmd_oe, done}, 136'd0);
            cmd_in = 1'b1;
        end
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            cmd_in = rsp[len-1-k];
        end
        @(negedge clk);
        cmd_in = 1'b1;
        chk(done == 1'b1, {tag, " R8 done after last bit"}, {135'b0, done}, 136'd1);
        chk(crc_err == exp_err, {tag, " R9 crc flag"}, {135'b0, crc_err}, {135'b0, exp_err});
        @(negedge clk);
        chk(!done, "R8 done single pulse", {135'b0, done}, 136'd0);
    endtask

    task automatic read_rsp(input logic [135:0] rsp, input int len, input string tag);
        logic [135:0] got = '0;
        int nb = len / 8;
        @(negedge clk); rxq_ptr_rst = 1'b1;
        @(negedge clk); rxq_ptr_rst = 1'b0; rxq_rd_en = 1'b1;
        for (int i = 0; i < nb; i++) begin
            if (i > 0) @(negedge clk);
            got[len-1-8*i -: 8] = rxq_rd_data;
        end
        @(negedge clk); rxq_rd_en = 1'b0;
        chk(got == rsp, {tag, " R7 R10 bytes"}, got, rsp);
    endtask

    task automatic build_rsp(input logic short_fmt, input logic corrupt,
                             output logic [135:0] rsp, output int len);
        if (short_fmt) begin
            logic [39:0] h = {2'b00, 6'($urandom), $urandom};
            logic [6:0]  c = crc7_ref({80'b0, h}, 40);
            rsp = {88'b0, h, c, 1'b1};
            len = 48;
            if (corrupt) rsp[20] = ~rsp[20];
        end else begin
            logic [119:0] b = {24'($urandom), $urandom, $urandom, $urandom};
            logic [6:0]   c = crc7_ref(b, 120);
            rsp = {2'b00, 6'h3F, b, c, 1'b1};
            len = 136;
            if (corrupt) rsp[50] = ~rsp[50];
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog R8: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [135:0] rsp;
        int len;
        int seed_unused;
        seed_unused = $urandom(32'h5EED);

        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!cmd_oe && cmd_out && !done && !crc_err, "R1 reset outputs",
            {132'b0, cmd_oe, cmd_out, done, crc_err}, 136'b0100);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_oe && cmd_out, "R1 idle line after reset", {134'b0, cmd_oe, cmd_out}, 136'b01);

        // R4 known answer: index 0, zero argument -> last byte 0x95
        reset_txq();
        push_cmd(8'h40, 32'h0);
        send_frame(48'h40_0000_0000_95, "R2 R3 R4 CMD0 frame", 0);
        expect_done_no_rsp("R8 done after command");

        // R4 known answer: index 8, argument 0x1AA -> last byte 0x87
        reset_txq();
        push_cmd(8'h48, 32'h0000_01AA);
        send_frame(48'h48_0000_01AA_87, "R4 CMD8 frame", 0);
        expect_done_no_rsp("R8 done after CMD8");

        // R5 pointer reset discards stale bytes; R3 upper bits of first byte ignored
        push_cmd(8'hFF, 32'hDEAD_BEEF);
        reset_txq();
        push_cmd(8'hC5, 32'h1234_5678);
        send_frame(frame_of(6'h05, 32'h1234_5678), "R5 R3 frame after pointer reset", 0);
        expect_done_no_rsp("R8 done");

        // R5 wrap: next command continues at byte 5 and wraps at 8
        push_cmd(8'h11, 32'hCAFE_F00D);
        send_frame(frame_of(6'h11, 32'hCAFE_F00D), "R5 wrapped queue frame", 0);
        expect_done_no_rsp("R8 done");

        // R11 cmd_en pulse during a frame is ignored
        reset_txq();
        push_cmd(8'h0D, 32'h0BAD_0001);
        send_frame(frame_of(6'h0D, 32'h0BAD_0001), "R11 frame with mid pulse", 1);
        expect_done_no_rsp("R11 done");
        @(negedge clk);
        chk(!cmd_oe, "R11 no second frame", {135'b0, cmd_oe}, 136'd0);

        // R7 R9 directed: short, long, corrupted with and without check
        reset_txq(); push_cmd(8'h02, 32'h0); arm(1'b0, 1'b0);
        send_frame(frame_of(6'h02, 32'h0), "R2 long rsp cmd", 0);
        build_rsp(1'b0, 1'b0, rsp, len);
        drive_rsp(rsp, len, 3, 1'b0, "R7 136-bit good");
        read_rsp(rsp, len, "R7 136-bit");

        // R10 pointer reset after partial read returns byte 0
        @(negedge clk); rxq_rd_en = 1'b1;
        @(negedge clk); rxq_rd_en = 1'b0; rxq_ptr_rst = 1'b1;
        @(negedge clk); rxq_ptr_rst = 1'b0;
        chk(rxq_rd_data == rsp[135:128], "R10 read pointer reset",
            {128'b0, rxq_rd_data}, {128'b0, rsp[135:128]});

        reset_txq(); push_cmd(8'h0D, 32'h1); arm(1'b1, 1'b0);
        send_frame(frame_of(6'h0D, 32'h1), "R2 short rsp cmd", 0);
        build_rsp(1'b1, 1'b1, rsp, len);
        drive_rsp(rsp, len, 5, 1'b1, "R9 48-bit corrupted");
        read_rsp(rsp, len, "R7 48-bit");

        reset_txq(); push_cmd(8'h01, 32'h00FF_8000); arm(1'b1, 1'b1);
        send_frame(frame_of(6'h01, 32'h00FF_8000), "R2 crc-off cmd", 0);
        build_rsp(1'b1, 1'b1, rsp, len);
        drive_rsp(rsp, len, 2, 1'b0, "R9 check disabled");

        // random mix
        for (int it = 0; it < 12; it++) begin
            logic [5:0]  idx = 6'($urandom);
            logic [31:0] arg = $urandom;
            bit want = 1'($urandom);
            logic sf = 1'($urandom);
            logic off = 1'($urandom);
            logic bad = 1'($urandom);
            int gap = 1 + int'($urandom % 8);
            reset_txq();
            push_cmd({2'($urandom), idx}, arg);
            if (want) arm(sf, off);
            send_frame(frame_of(idx, arg), "R3 R4 random frame", 0);
            if (want) begin
                build_rsp(sf, bad, rsp, len);
                drive_rsp(rsp, len, gap, bad && !off, "R7 R9 random rsp");
                read_rsp(rsp, len, "R7 random");
            end else begin
                expect_done_no_rsp("R8 random done");
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule